// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block is the coherence engine of one node on a shared snooping bus. It fronts a small direct-mapped, write-back cache. Each line holds one tag, one data word and a coherence state: invalid, shared, exclusive or modified. The processor side issues loads and stores through a valid/ready handshake. When a load or store cannot finish locally, the controller requests the bus, drives one transaction when it is granted, and stalls the processor until that work is done.

Every transaction that other nodes place on the bus is presented on the snoop inputs. The controller looks it up in its own lines, drives the wired-OR shared contribution, and changes its line state. When it owns dirty data for the snooped address, it supplies that data and cancels the memory response. When a node reads a block and no other cache claims a copy, it installs the line as a clean sole copy. A later store to that line then completes with no bus traffic. On a snooped read that takes data from a dirty owner, the memory side is expected to capture the supplied word.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid. No snooped read reports a copy, `bus_req` is low, `bus_cmd` is 0 (none) and `cpu_ready` is low while no request is presented.
- R2: A load miss drives `bus_cmd`=1 (read) with the load address in the grant cycle. The line is installed exclusive if `bus_shared_in` is low when `bus_rsp_valid` arrives, and shared otherwise.
- R3: A load that hits a valid line with a matching tag raises `cpu_ready` in the same cycle with the stored word on `cpu_rdata` and makes no bus request.
- R4: A store that hits an exclusive or modified line completes with no bus request and leaves the line modified, holding the new word.
- R5: A store that hits a shared line requests the bus and drives `bus_cmd`=3 (invalidate) with its address when granted. The line then becomes modified and the store completes.
- R6: A store miss drives `bus_cmd`=2 (read-exclusive). The line is installed modified and the store word is written into it.
- R7: A snooped read (`snp_cmd`=1) raises `snp_shared` in the same cycle when it hits a valid line, and leaves it low on a miss.
- R8: A snooped read that hits a modified line raises `snp_supply` with the line's word on `snp_data` and downgrades the line to shared. A snooped read that hits an exclusive line downgrades it to shared without supplying data.
- R9: A snooped invalidate (`snp_cmd`=3) or read-exclusive (`snp_cmd`=2) that hits a valid line makes it invalid. A read-exclusive that hits a modified line also supplies its word.
- R10: A conflict miss whose victim is modified first drives `bus_cmd`=4 (write-back) with the victim address {victim tag, index} and the victim word, then the fetch. A clean victim is dropped with no write-back.
- R11: If a shared line with a pending store upgrade is invalidated by a snoop before the grant, the controller issues read-exclusive instead of invalidate.
- R12: A snoop lookup takes priority: while `snp_valid` is high, `cpu_ready` stays low even for a request that would hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor request present, held until ready |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits are the line index |
| cpu_wdata | input | DATA_W | Store word |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load result, valid with cpu_ready |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant; the transaction is driven in this cycle |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_rsp_valid | input | 1 | Fill word for the outstanding read or read-exclusive |
| bus_rsp_data | input | DATA_W | Fill word |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled with the fill |
| snp_valid | input | 1 | Transaction from another node is on the bus |
| snp_cmd | input | 3 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This node's contribution to the wired-OR shared line |
| snp_supply | output | 1 | This node supplies the word; memory response is cancelled |
| snp_data | output | DATA_W | Supplied word |

## Verification
The bench builds the block with ADDR_W=8, IDX_W=2 and DATA_W=16. That gives four lines and a 6-bit tag. Random traffic draws addresses from only four tags over the four indices, so conflict evictions of dirty and clean victims, snoop hits on every state and refills after invalidation all happen often. A bench reference model of the four lines and the memory predicts every bus command, its address and data, and every snoop reply.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } coh_t;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_INV  = 3'd3,
    BC_WB   = 3'd4
  } bcmd_t;

  // State a hit line takes after another node's transaction.
  function automatic coh_t coh_after_snoop(coh_t s, bcmd_t c);
    case (c)
      BC_RD:         return (s == ST_I) ? ST_I : ST_S;
      BC_RDX, BC_INV: return ST_I;
      default:       return s;
    endcase
  endfunction

  // State a line is installed in when its fill word arrives.
  function automatic coh_t coh_on_fill(logic is_store, logic others_hold);
    if (is_store)    return ST_M;
    if (others_hold) return ST_S;
    return ST_E;
  endfunction

  // Stores that finish without the bus.
  function automatic logic coh_store_local(coh_t s);
    return (s == ST_E) || (s == ST_M);
  endfunction

endpackage

// File: rtl/mesi_line_array.sv
`timescale 1ns/1ps
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  look_idx,
  output coh_t              look_st,
  output logic [TAG_W-1:0]  look_tag,
  output logic [DATA_W-1:0] look_dat,
  input  logic [IDX_W-1:0]  snp_idx,
  output coh_t              snp_st,
  output logic [TAG_W-1:0]  snp_tag,
  output logic [DATA_W-1:0] snp_dat,
  input  logic              fill_we,
  input  logic [IDX_W-1:0]  fill_idx,
  input  coh_t              fill_st,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_dat,
  input  logic              snp_we,
  input  coh_t              snp_st_new
);
  localparam int LINES = 1 << IDX_W;

  coh_t              st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  // Snoop update is applied last so it wins on a shared index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_we && fill_idx == IDX_W'(i)) begin
          st_q[i]  <= fill_st;
          tag_q[i] <= fill_tag;
          dat_q[i] <= fill_dat;
        end
        if (snp_we && snp_idx == IDX_W'(i)) st_q[i] <= snp_st_new;
      end
    end
  end

  assign look_st  = st_q[look_idx];
  assign look_tag = tag_q[look_idx];
  assign look_dat = dat_q[look_idx];
  assign snp_st   = st_q[snp_idx];
  assign snp_tag  = tag_q[snp_idx];
  assign snp_dat  = dat_q[snp_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
`timescale 1ns/1ps
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  bcmd_t             snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag_in,
  input  coh_t              line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_dat,
  output logic              hit_shared,
  output logic              hit_supply,
  output logic [DATA_W-1:0] supply_dat,
  output logic              upd_we,
  output coh_t              upd_st
);
  logic snp_hit;
  logic cmd_fetch;

  assign snp_hit    = snp_valid && (line_st != ST_I) && (line_tag == snp_tag_in);
  assign cmd_fetch  = (snp_cmd == BC_RD) || (snp_cmd == BC_RDX);
  assign hit_shared = snp_hit && (snp_cmd == BC_RD);
  assign hit_supply = snp_hit && cmd_fetch && (line_st == ST_M);
  assign supply_dat = line_dat;
  assign upd_st     = coh_after_snoop(line_st, snp_cmd);
  assign upd_we     = snp_hit && (cmd_fetch || snp_cmd == BC_INV);

  // R8/R9: supplying a dirty word always changes the owner's state
  a_r8_supply_moves_state: assert property (@(posedge clk) disable iff (!rst_n)
    hit_supply |-> upd_we && upd_st != ST_M);

  // R9: an invalidate hit never leaves a valid copy behind
  a_r9_inv_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_we && snp_cmd == BC_INV) |-> upd_st == ST_I);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_data,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_RSP} phase_t;

  phase_t            ph_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_wr_q;

  // Named internal events
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag_want;
  coh_t              cst;
  logic [TAG_W-1:0]  ctag;
  logic [DATA_W-1:0] cdat;
  logic              look_hit;
  logic              cpu_go, rd_hit, wr_local, need_bus;
  logic              victim_dirty;
  bcmd_t             cmd_now;
  logic [ADDR_W-1:0] addr_now;
  logic              fill_we;
  coh_t              fill_st;
  logic [TAG_W-1:0]  fill_tag;
  logic [DATA_W-1:0] fill_dat;
  coh_t              sst;
  logic [TAG_W-1:0]  stag;
  logic [DATA_W-1:0] sdat;
  logic              snp_we;
  coh_t              snp_st_new;

  assign look_idx      = (ph_q == P_IDLE) ? cpu_addr[IDX_W-1:0] : req_addr_q[IDX_W-1:0];
  assign look_tag_want = (ph_q == P_IDLE) ? cpu_addr[ADDR_W-1:IDX_W] : req_addr_q[ADDR_W-1:IDX_W];
  assign look_hit      = (cst != ST_I) && (ctag == look_tag_want);

  mesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .look_idx(look_idx), .look_st(cst), .look_tag(ctag), .look_dat(cdat),
    .snp_idx(snp_addr[IDX_W-1:0]), .snp_st(sst), .snp_tag(stag), .snp_dat(sdat),
    .fill_we(fill_we), .fill_idx(look_idx), .fill_st(fill_st),
    .fill_tag(fill_tag), .fill_dat(fill_dat),
    .snp_we(snp_we), .snp_st_new(snp_st_new)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(bcmd_t'(snp_cmd)),
    .snp_tag_in(snp_addr[ADDR_W-1:IDX_W]),
    .line_st(sst), .line_tag(stag), .line_dat(sdat),
    .hit_shared(snp_shared), .hit_supply(snp_supply), .supply_dat(snp_data),
    .upd_we(snp_we), .upd_st(snp_st_new)
  );

  // Processor side: a snoop in the same cycle stalls the lookup.
  assign cpu_go       = (ph_q == P_IDLE) && cpu_valid && !snp_valid;
  assign rd_hit       = cpu_go && !cpu_write && look_hit;
  assign wr_local     = cpu_go && cpu_write && look_hit && coh_store_local(cst);
  assign need_bus     = cpu_go && !rd_hit && !wr_local;
  assign victim_dirty = (cst == ST_M) && !look_hit;
  assign cpu_ready    = rd_hit || wr_local;
  assign cpu_rdata    = cdat;
  assign bus_req      = (ph_q == P_REQ);

  always_comb begin
    cmd_now  = BC_NONE;
    addr_now = req_addr_q;
    fill_we  = 1'b0;
    fill_st  = cst;
    fill_tag = ctag;
    fill_dat = cdat;
    unique case (ph_q)
      P_IDLE: if (wr_local) begin
        fill_we  = 1'b1;
        fill_st  = ST_M;
        fill_dat = cpu_wdata;
      end
      P_REQ: if (bus_gnt) begin
        if (victim_dirty) begin
          cmd_now  = BC_WB;
          addr_now = {ctag, look_idx};
          fill_we  = 1'b1;
          fill_st  = ST_I;
        end else if (req_wr_q && look_hit && cst == ST_S) begin
          cmd_now = BC_INV;
          fill_we = 1'b1;
          fill_st = ST_M;
        end else begin
          cmd_now = req_wr_q ? BC_RDX : BC_RD;
        end
      end
      P_RSP: if (bus_rsp_valid) begin
        fill_we  = 1'b1;
        fill_st  = coh_on_fill(req_wr_q, bus_shared_in);
        fill_tag = look_tag_want;
        fill_dat = bus_rsp_data;
      end
      default: ;
    endcase
  end

  assign bus_cmd   = cmd_now;
  assign bus_addr  = addr_now;
  assign bus_wdata = cdat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= P_IDLE;
      req_addr_q <= '0;
      req_wr_q   <= 1'b0;
    end else begin
      unique case (ph_q)
        P_IDLE: if (need_bus) begin
          ph_q       <= P_REQ;
          req_addr_q <= cpu_addr;
          req_wr_q   <= cpu_write;
        end
        P_REQ: begin
          if (cmd_now == BC_INV) ph_q <= P_IDLE;
          else if (cmd_now == BC_RD || cmd_now == BC_RDX) ph_q <= P_RSP;
        end
        P_RSP: if (bus_rsp_valid) ph_q <= P_IDLE;
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  // R1: nothing is driven on the bus without an own request and grant
  a_r1_bus_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != BC_NONE) |-> (bus_req && bus_gnt));

  // R2: a plain read is only fetched for a load
  a_r2_read_for_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_RD) |-> !req_wr_q);

  // R5: an invalidate is only broadcast over a shared copy for a store
  a_r5_inv_from_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_INV) |-> (cst == ST_S && req_wr_q));

  // R6: read-exclusive is only fetched for a store
  a_r6_rdx_for_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_RDX) |-> req_wr_q);

  // R10: a write-back is followed by a further request for the fetch
  a_r10_wb_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_WB) |=> bus_req);

  // R12: the processor never completes in a snoop cycle
  a_r12_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready);

endmodule

// File: tb/mesi_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_bench;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cpu_valid, cpu_write, cpu_ready;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          bus_req, bus_gnt;
  logic [2:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_rsp_valid, bus_shared_in;
  logic [DW-1:0] bus_rsp_data;
  logic          snp_valid, snp_shared, snp_supply;
  logic [2:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic [DW-1:0] snp_data;

  mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u_mesi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data),
    .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_supply(snp_supply),
    .snp_data(snp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model: states I=0 S=1 E=2 M=3
  int            m_st  [4];
  logic [5:0]    m_tag [4];
  logic [DW-1:0] m_dat [4];
  logic [DW-1:0] mem   [256];

  function automatic logic [DW-1:0] mem_seed(logic [7:0] a);
    return {a, ~a} ^ 16'h3c3c;
  endfunction

  function automatic bit m_hit(logic [7:0] a);
    return m_st[a[1:0]] != 0 && m_tag[a[1:0]] == a[7:2];
  endfunction

  task automatic check(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic snoop_op(int c, logic [7:0] a, bit hold_cpu, string rq);
    int  ix;
    bit  hit, e_shr, e_sup;
    logic [DW-1:0] e_dat;
    ix    = a[1:0];
    hit   = m_hit(a);
    e_shr = hit && c == 1;
    e_sup = hit && m_st[ix] == 3 && (c == 1 || c == 2);
    e_dat = m_dat[ix];
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 3'(c); snp_addr = a;
    if (hold_cpu) begin
      cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = a;
    end
    #1;
    check(snp_shared == e_shr, {rq, " snp_shared"}, snp_shared, e_shr);
    check(snp_supply == e_sup, {rq, " snp_supply"}, snp_supply, e_sup);
    if (e_sup) check(snp_data == e_dat, {rq, " snp_data"}, snp_data, e_dat);
    if (hold_cpu) check(cpu_ready == 1'b0, "R12 stall under snoop", cpu_ready, 0);
    if (hit) begin
      if (c == 1) begin
        if (m_st[ix] == 3) mem[a] = m_dat[ix];
        m_st[ix] = 1;
      end else if (c == 2 || c == 3) begin
        m_st[ix] = 0;
      end
    end
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 3'd0;
    if (hold_cpu) cpu_valid = 1'b0;
  endtask

  task automatic cpu_op(bit wr, logic [7:0] a, logic [DW-1:0] wd, bit shr,
                        bit steal, string rq);
    int ix, n_exp, n, st;
    bit hit, done;
    int exp_cmd [2];
    logic [7:0] exp_a [2];
    logic [DW-1:0] exp_d, e_rd;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
    if (steal) snoop_op(3, a, 1'b0, "R11 steal");
    ix = a[1:0]; hit = m_hit(a); st = m_st[ix];
    n_exp = 0; exp_d = '0; e_rd = m_dat[ix];
    if (!hit && st == 3) begin
      exp_cmd[0] = 4; exp_a[0] = {m_tag[ix], 2'(ix)}; exp_d = m_dat[ix];
      mem[exp_a[0]] = m_dat[ix];
      n_exp = 1;
    end
    if (!wr) begin
      if (!hit) begin
        exp_cmd[n_exp] = 1; exp_a[n_exp] = a; n_exp++;
        m_st[ix] = shr ? 1 : 2; m_tag[ix] = a[7:2]; m_dat[ix] = mem[a];
        e_rd = mem[a];
      end
    end else begin
      if (hit && st == 1) begin
        exp_cmd[n_exp] = 3; exp_a[n_exp] = a; n_exp++;
      end else if (!hit) begin
        exp_cmd[n_exp] = 2; exp_a[n_exp] = a; n_exp++;
      end
      m_st[ix] = 3; m_tag[ix] = a[7:2]; m_dat[ix] = wd;
    end
    n = 0; done = 0;
    for (int cyc = 0; cyc < 40 && !done; cyc++) begin
      #1;
      if (cpu_ready) begin
        if (!wr) check(cpu_rdata == e_rd, {rq, " load data"}, cpu_rdata, e_rd);
        done = 1;
      end else if (bus_req) begin
        bus_gnt = 1'b1;
        #1;
        if (n < n_exp) begin
          check(bus_cmd == 3'(exp_cmd[n]), {rq, " bus_cmd"}, bus_cmd, exp_cmd[n]);
          check(bus_addr == exp_a[n], {rq, " bus_addr"}, bus_addr, exp_a[n]);
          if (exp_cmd[n] == 4) check(bus_wdata == exp_d, "R10 write-back data", bus_wdata, exp_d);
        end else begin
          check(1'b0, {rq, " extra bus command"}, bus_cmd, 0);
        end
        n++;
        if (bus_cmd == 3'd1 || bus_cmd == 3'd2) begin
          @(negedge clk);
          bus_gnt = 1'b0;
          bus_rsp_valid = 1'b1; bus_rsp_data = mem[bus_addr]; bus_shared_in = shr;
          @(negedge clk);
          bus_rsp_valid = 1'b0; bus_shared_in = 1'b0;
        end else begin
          @(negedge clk);
          bus_gnt = 1'b0;
        end
      end else begin
        @(negedge clk);
      end
    end
    check(done, {rq, " completion"}, done, 1);
    check(n == n_exp, {rq, " bus command count"}, n, n_exp);
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 256; i++) mem[i] = mem_seed(8'(i));
    for (int i = 0; i < 4; i++) begin
      m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
    end
    rst_n = 1'b0; cpu_valid = 0; cpu_write = 0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 0; bus_rsp_valid = 0; bus_rsp_data = '0; bus_shared_in = 0;
    snp_valid = 0; snp_cmd = '0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check(bus_req == 1'b0, "R1 bus_req", bus_req, 0);
    check(bus_cmd == 3'd0, "R1 bus_cmd", bus_cmd, 0);
    check(cpu_ready == 1'b0, "R1 cpu_ready", cpu_ready, 0);
    for (int i = 0; i < 4; i++) snoop_op(1, 8'(i + 4), 1'b0, "R1 all invalid");

    // R2 exclusive fill, R3 hit
    cpu_op(1'b0, 8'h04, '0, 1'b0, 1'b0, "R2 load miss");
    cpu_op(1'b0, 8'h04, '0, 1'b0, 1'b0, "R3 load hit");
    // R4 silent upgrade from exclusive
    cpu_op(1'b1, 8'h04, 16'hbeef, 1'b0, 1'b0, "R4 silent store");
    // R7/R8 snooped read on modified supplies and downgrades
    snoop_op(1, 8'h04, 1'b0, "R8 supply from modified");
    // R5 store to shared broadcasts invalidate
    cpu_op(1'b1, 8'h04, 16'h1234, 1'b0, 1'b0, "R5 upgrade");
    // R10 dirty victim written back, then shared fill (R2)
    cpu_op(1'b0, 8'h08, '0, 1'b1, 1'b0, "R10 dirty victim");
    cpu_op(1'b1, 8'h08, 16'h0f0f, 1'b0, 1'b0, "R2 shared fill then R5");
    snoop_op(1, 8'h0c, 1'b0, "R7 snoop miss");
    // R8 exclusive downgrades without supply
    cpu_op(1'b0, 8'h01, '0, 1'b0, 1'b0, "R2 load idx1");
    snoop_op(1, 8'h01, 1'b0, "R8 exclusive to shared");
    cpu_op(1'b1, 8'h01, 16'h7777, 1'b0, 1'b0, "R8 after downgrade needs R5");
    // R9 invalidate then refetch
    snoop_op(3, 8'h01, 1'b0, "R9 invalidate");
    cpu_op(1'b0, 8'h01, '0, 1'b0, 1'b0, "R9 refetch");
    // R6 store miss, R9 read-exclusive supply
    cpu_op(1'b1, 8'h02, 16'hcafe, 1'b0, 1'b0, "R6 store miss");
    snoop_op(2, 8'h02, 1'b0, "R9 rdx supply");
    cpu_op(1'b0, 8'h02, '0, 1'b0, 1'b0, "R9 refetch after rdx");
    // R11 lost upgrade race
    cpu_op(1'b0, 8'h06, '0, 1'b1, 1'b0, "R11 setup");
    cpu_op(1'b1, 8'h06, 16'h5555, 1'b0, 1'b1, "R11 rdx after steal");
    // R12 snoop priority over a hitting load
    snoop_op(0, 8'h06, 1'b1, "R12 idle snoop");
    // R10 clean victim silent
    cpu_op(1'b0, 8'h03, '0, 1'b0, 1'b0, "R10 clean fill");
    cpu_op(1'b0, 8'h07, '0, 1'b0, 1'b0, "R10 clean victim");

    for (int k = 0; k < 500; k++) begin
      logic [31:0] r;
      logic [7:0]  a;
      r = $urandom;
      a = {4'b0, r[5:4], r[1:0]};
      if (r[8:6] < 3'd4)
        cpu_op(r[9], a, r[31:16], r[10], 1'b0, "R2-R6 random cpu");
      else
        snoop_op(1 + int'(r[15:12]) % 3, a, r[11], "R7-R9 random snoop");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule